// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block derives the serial clock of an SPI master from its parent clock. A single 32-bit configuration register sets three 6-bit fields: the divider, the count at which the serial clock goes high, and the count at which it goes low. A counter steps through one serial-clock period of divider+1 parent cycles and then wraps. Because the rise and fall points are set separately, software chooses the duty cycle. For an even split it programs the low count to the divider value and the high count to ((divider+1)/2 - 1).

The shift logic of the master does not look at the serial clock level. It uses two one-cycle strobes, one for each serial-clock edge. A transfer-busy input tells the generator whether a register write may restart its phase. The register also stores a clock-source select bit and returns it on read-back. The multiplexer that this bit would steer is not part of this block.

Top module: `spi_sck_gen`

## Requirements
- R1: The counter runs from 0 up to the divider value n (field cfg[17:12]) and then wraps to 0, so one serial-clock period lasts n+1 parent cycles. With a 6-bit divider the slowest clock is the parent clock divided by 64.
- R2: The serial clock goes high in the cycle after the counter equals the high count (cfg[11:6]). It goes low in the cycle after the counter equals the low count (cfg[5:0]). When both counts are equal, the low count wins and the clock stays low.
- R3: `sck_rise` is high for exactly the one parent cycle in which `sck` has just gone from 0 to 1. `sck_fall` is high for exactly the one cycle in which `sck` has just gone from 1 to 0. The two strobes are never high together.
- R4: A divider value of 0 is treated as 1, so the fastest serial clock is half the parent clock.
- R5: A register write while `xfer_busy` is low restarts the period. In the next cycle the counter is 0, `sck` is low and both strobes are low.
- R6: A register write while `xfer_busy` is high updates the stored fields but does not restart the counter or disturb the running clock.
- R7: While `gen_en` is low, `sck` is held low, no strobes are produced and the counter is held at 0. When `gen_en` rises again, the first period starts from count 0.
- R8: `cfg_rdata` returns bit 31 (clock-source select) and bits 17:0 as last written. All other bits read as 0.
- R9: After reset, `sck`, both strobes and `cfg_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Generator enable |
| xfer_busy | input | 1 | A transfer is in progress; a register write must not restart the phase |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration |
| sck | output | 1 | Serial clock |
| sck_rise | output | 1 | One-cycle strobe on each serial-clock rising edge |
| sck_fall | output | 1 | One-cycle strobe on each serial-clock falling edge |

## Verification
The assertions take `gen_en`, `xfer_busy` and `cfg_we` to be synchronous to the parent clock and stable between edges. They also take a write strobe to last one cycle per intended write. The bench changes every input only on the falling edge and pulses `cfg_we` for a single cycle. It sweeps every divider from 0 to 7 with every in-range high/low count pair, and adds a full-length even split at the largest divider. For each cycle it computes the expected clock from the most recent compare hit, working from count position modulo the period. It also covers a busy write in mid-period, a disable interval, and an all-ones write with equal counts.

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int FIELD_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        gen_en,
  input  logic        xfer_busy,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        sck,
  output logic        sck_rise,
  output logic        sck_fall
);
  localparam int REG_W   = 32;
  localparam int FLD_TOP = 3 * FIELD_W;
  localparam logic [REG_W-1:0] KEEP_MASK =
    {1'b1, {(REG_W-1-FLD_TOP){1'b0}}, {FLD_TOP{1'b1}}};

  logic [REG_W-1:0]   cfg_q;
  logic [FIELD_W-1:0] cnt_q, lo_cnt, hi_cnt, div_n, last_cnt;
  logic               restart, hit_lo, hit_hi, sck_nxt;

  assign lo_cnt   = cfg_q[FIELD_W-1:0];
  assign hi_cnt   = cfg_q[2*FIELD_W-1:FIELD_W];
  assign div_n    = cfg_q[FLD_TOP-1:2*FIELD_W];
  assign last_cnt = (div_n == '0) ? FIELD_W'(1) : div_n;

  assign restart  = !gen_en || (cfg_we && !xfer_busy);
  assign hit_lo   = (cnt_q == lo_cnt);
  assign hit_hi   = (cnt_q == hi_cnt) && !hit_lo;
  assign sck_nxt  = hit_lo ? 1'b0 : (hit_hi ? 1'b1 : sck);

  assign cfg_rdata = cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cnt_q    <= '0;
      sck      <= 1'b0;
      sck_rise <= 1'b0;
      sck_fall <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata & KEEP_MASK;
      if (restart) begin
        cnt_q    <= '0;
        sck      <= 1'b0;
        sck_rise <= 1'b0;
        sck_fall <= 1'b0;
      end else begin
        cnt_q    <= (cnt_q >= last_cnt) ? '0 : cnt_q + 1'b1;
        sck      <= sck_nxt;
        sck_rise <= sck_nxt && !sck;
        sck_fall <= !sck_nxt && sck;
      end
    end
  end

  // wrap at the end of the period
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && !cfg_we && cnt_q >= last_cnt) |=> (cnt_q == '0));

  p_low_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == lo_cnt) |=> !sck);

  p_rise_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |-> (sck && !$past(sck)));

  p_fall_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall |-> (!sck && $past(sck)));

  p_tick_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise && sck_fall));

  p_idle_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !xfer_busy) |=> (cnt_q == '0 && !sck && !sck_rise && !sck_fall));

  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (!sck && !sck_rise && !sck_fall));

  p_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & KEEP_MASK)));
endmodule

// File: tb/spi_sck_gen_tb.sv
`timescale 1ns/1ps
module spi_sck_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gen_en = 1'b0;
  logic xfer_busy = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic sck, sck_rise, sck_fall;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_sck_gen u_dut (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .xfer_busy(xfer_busy),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sck(sck), .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  // Expected clock k cycles after a restart: the most recent compare hit decides.
  function automatic logic exp_sck(int k, int p, int hi, int lo);
    for (int j = k - 1; j >= 0; j--) begin
      if (j % p == lo) return 1'b0;
      if (j % p == hi) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [31:0] mk(int n, int hi, int lo);
    return (32'(n) << 12) | (32'(hi) << 6) | 32'(lo);
  endfunction

  task automatic check_cycle(int k, int p, int hi, int lo, string tag);
    logic e, ep;
    e  = exp_sck(k, p, hi, lo);
    ep = (k > 0) ? exp_sck(k - 1, p, hi, lo) : 1'b0;
    chk(tag, 32'(sck), 32'(e));
    chk("R3 rise", 32'(sck_rise), 32'(e && !ep));
    chk("R3 fall", 32'(sck_fall), 32'(!e && ep));
  endtask

  task automatic wr(logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 sck", 32'(sck), 0);
    chk("R9 rise", 32'(sck_rise), 0);
    chk("R9 fall", 32'(sck_fall), 0);
    chk("R9 rdata", cfg_rdata, 0);
    rst_n = 1'b1; gen_en = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R5 sweep over small dividers and all in-range compare pairs
    for (int n = 0; n < 8; n++) begin
      for (int hi = 0; hi <= ((n == 0) ? 1 : n); hi++) begin
        for (int lo = 0; lo <= ((n == 0) ? 1 : n); lo++) begin
          int p;
          p = ((n == 0) ? 1 : n) + 1;
          wr(mk(n, hi, lo));
          chk("R5 restart low", 32'(sck), 0);
          for (int k = 0; k < 2 * p + 3; k++) begin
            check_cycle(k, p, hi, lo, (n == 0) ? "R4 sck" : "R1 R2 sck");
            @(negedge clk);
          end
        end
      end
    end

    // R1 slowest clock: even split at divider 63, period 64
    wr(mk(63, 31, 63));
    for (int k = 0; k < 130; k++) begin
      check_cycle(k, 64, 31, 63, "R1 slow sck");
      @(negedge clk);
    end

    // R6 busy write leaves the phase running
    wr(mk(5, 1, 4));
    xfer_busy = 1'b1;
    for (int k = 0; k < 21; k++) begin
      check_cycle(k, 6, 1, 4, "R6 sck");
      cfg_we = (k == 8);
      cfg_wdata = mk(5, 1, 4) | 32'h8000_0000;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    xfer_busy = 1'b0;
    chk("R8 src bit", cfg_rdata, mk(5, 1, 4) | 32'h8000_0000);

    // R7 disable holds everything quiet, then restarts from count 0
    wr(mk(3, 1, 3));
    repeat (5) @(negedge clk);
    gen_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R7 sck", 32'(sck), 0);
      chk("R7 rise", 32'(sck_rise), 0);
      chk("R7 fall", 32'(sck_fall), 0);
    end
    gen_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      check_cycle(k, 4, 1, 3, "R7 resume");
      @(negedge clk);
    end

    // R8 reserved bits drop; R2 equal counts keep sck low
    wr(32'hFFFF_FFFF);
    chk("R8 mask", cfg_rdata, 32'h8003_FFFF);
    for (int k = 0; k < 140; k++) begin
      chk("R2 equal counts", 32'(sck), 0);
      chk("R3 no rise", 32'(sck_rise), 0);
      @(negedge clk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule